// File: doc/BRIEF.md
# Handshaked Byte Shift Transfer Engine

This block moves single bytes between a host and a packet buffer on the device side. Three active-low handshake lines in an 8-bit port register carry the protocol. The block drives a request line. The host drives an acknowledge line and an in-progress line. The host writes the port register. A step happens on a write that asserts in-progress (drives it low) and changes the acknowledge/in-progress pair compared with the last value written.

In the inbound direction, a packet of up to 128 bytes is first loaded through a packet port. Each step then places the next byte in the shift register. The request line stays low while unread bytes remain.

In the outbound direction, the direction bit of the control register is set. Each step appends the current shift register value to a 16-byte capture buffer. When the direction bit is cleared, the captured bytes are presented on the packet-out port as one packet. Every step that moves a byte, and every packet load, raises a one-cycle flag pulse that a host interrupt controller can use. The block does not decode the packets.

Top module: `byte_xfer_engine`

## Requirements
- R1: After reset, `portb_o` reads 8'hFF, `sr_rdata_o` reads 0, and neither `out_valid_o` nor `flag_set_o` is high.
- R2: `portb_o[3]` (request, active low) is 0 while unread inbound bytes remain and 1 once the inbound packet is used up; the other bits of `portb_o` echo the last port write.
- R3: A step occurs only on a port write with bit 5 (in-progress) equal to 0 and the pair {bit 5, bit 4} different from that pair in the previous port write. Any other port write moves no byte and raises no flag.
- R4: On a step with inbound bytes pending, the next byte loads into the shift register, the read position advances, and `flag_set_o` is high in the cycle after the write edge.
- R5: After a step with no inbound byte pending while the direction bit is 0, `sr_rdata_o` reads 0 until the next packet load or shift-register write.
- R6: With control bit 4 set to 1, each step appends the shift register value to the outbound buffer if it holds fewer than 16 bytes, and the step raises `flag_set_o` even when the buffer is full.
- R7: A control write that clears bit 4 while it was 1 pulses `out_valid_o` for one cycle with `out_len_o` equal to the captured count, then the count returns to 0. No pulse is given when the count is 0.
- R8: A packet load (`pkt_start_i`) resets the read position to 0, takes the new length, and raises `flag_set_o` in the next cycle. This also holds in the middle of a packet.
- R9: During the `out_valid_o` pulse, captured byte k sits at `out_data_o[8k+7:8k]`, in capture order.
- R10: An inbound packet of the full 128 bytes is delivered byte by byte in buffer order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| portb_we_i | input | 1 | Port register write strobe |
| portb_wdata_i | input | 8 | Port write data (bit 4 acknowledge, bit 5 in-progress) |
| portb_o | output | 8 | Port register, bit 3 driven as request |
| acr_we_i | input | 1 | Control register write strobe |
| acr_wdata_i | input | 8 | Control write data, bit 4 selects outbound |
| sr_we_i | input | 1 | Shift register write strobe |
| sr_wdata_i | input | 8 | Shift register write data |
| sr_rdata_o | output | 8 | Shift register read data |
| pkt_wr_i | input | 1 | Inbound buffer byte write |
| pkt_addr_i | input | 7 | Inbound buffer byte address |
| pkt_data_i | input | 8 | Inbound buffer byte data |
| pkt_start_i | input | 1 | Start delivery of a loaded inbound packet |
| pkt_len_i | input | 8 | Inbound packet length, 1 to 128 |
| out_valid_o | output | 1 | One-cycle outbound packet strobe |
| out_len_o | output | 5 | Outbound packet byte count |
| out_data_o | output | 128 | Outbound bytes, byte k at bits 8k+7:8k |
| flag_set_o | output | 1 | One-cycle shift flag set pulse |

## Verification
The assertions assume that at most one of the port, control, shift-register and packet-start accesses occurs in any cycle. A step therefore never coincides with a load or with the close of an outbound packet. The bench drives each access in its own cycle. It writes inbound buffer bytes only before a packet is started, and it keeps load lengths within 1 to 128. Under these conditions the checked read position never passes the length and the outbound count stays within 16.

// File: rtl/bxe_pkg.sv
package bxe_pkg;
  localparam int unsigned REQ_BIT = 3;
  localparam int unsigned ACK_BIT = 4;
  localparam int unsigned TIP_BIT = 5;
  localparam int unsigned DIR_BIT = 4;
endpackage

// File: rtl/bxe_step_det.sv
module bxe_step_det
  import bxe_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic          step_o,
  output logic [DW-1:0] b_q_o
);
  logic [DW-1:0] b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   b_q <= '1;
    else if (we_i) b_q <= wdata_i;
  end

  assign step_o = we_i && !wdata_i[TIP_BIT] &&
                  ({wdata_i[TIP_BIT], wdata_i[ACK_BIT]} != {b_q[TIP_BIT], b_q[ACK_BIT]});
  assign b_q_o  = b_q;

  // R3
  repeat_no_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i == b_q) |-> !step_o);
endmodule

// File: rtl/bxe_in_buf.sv
module bxe_in_buf #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          start_i,
  input  logic [LW-1:0] start_len_i,
  input  logic          step_i,
  output logic          pending_o,
  output logic [DW-1:0] byte_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [LW-1:0] rd_idx_q, len_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_idx_q <= '0;
      len_q    <= '0;
    end else if (start_i) begin
      rd_idx_q <= '0;
      len_q    <= (start_len_i > LW'(DEPTH)) ? LW'(DEPTH) : start_len_i;
    end else if (step_i && pending_o) begin
      rd_idx_q <= rd_idx_q + 1'b1;
    end
  end

  assign pending_o = rd_idx_q < len_q;
  assign byte_o    = mem_q[rd_idx_q[AW-1:0]];

  // R2
  idx_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_q <= len_q);
  // R8
  start_rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> rd_idx_q == '0);
endmodule

// File: rtl/bxe_out_buf.sv
module bxe_out_buf #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                push_i,
  input  logic [DW-1:0]       byte_i,
  input  logic                close_i,
  output logic                valid_o,
  output logic [LW-1:0]       len_o,
  output logic [DEPTH*DW-1:0] data_o
);
  logic [LW-1:0] cnt_q;
  logic          room;

  assign room = cnt_q < LW'(DEPTH);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [DW-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               ent_q <= '0;
      else if (push_i && !close_i && cnt_q == LW'(g)) ent_q <= byte_i;
    end
    assign data_o[g*DW +: DW] = ent_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_o <= 1'b0;
      len_o   <= '0;
    end else begin
      valid_o <= 1'b0;
      if (close_i) begin
        valid_o <= cnt_q != '0;
        len_o   <= cnt_q;
        cnt_q   <= '0;
      end else if (push_i && room) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R6
  cnt_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LW'(DEPTH));
  // R7
  close_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i |=> cnt_q == '0);
  // R7
  valid_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> len_o != '0);
endmodule

// File: rtl/byte_xfer_engine.sv
module byte_xfer_engine
  import bxe_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         portb_we_i,
  input  logic [7:0]   portb_wdata_i,
  output logic [7:0]   portb_o,
  input  logic         acr_we_i,
  input  logic [7:0]   acr_wdata_i,
  input  logic         sr_we_i,
  input  logic [7:0]   sr_wdata_i,
  output logic [7:0]   sr_rdata_o,
  input  logic         pkt_wr_i,
  input  logic [6:0]   pkt_addr_i,
  input  logic [7:0]   pkt_data_i,
  input  logic         pkt_start_i,
  input  logic [7:0]   pkt_len_i,
  output logic         out_valid_o,
  output logic [4:0]   out_len_o,
  output logic [127:0] out_data_o,
  output logic         flag_set_o
);
  localparam int unsigned DW        = 8;
  localparam int unsigned IN_DEPTH  = 128;
  localparam int unsigned OUT_DEPTH = 16;

  logic          step, pending, in_step, out_push, close, dir, dry_q;
  logic [DW-1:0] b_q, in_byte, sr_q, acr_q, push_byte;

  bxe_step_det #(.DW(DW)) u_step (
    .clk_i, .rst_ni, .we_i(portb_we_i), .wdata_i(portb_wdata_i),
    .step_o(step), .b_q_o(b_q)
  );

  bxe_in_buf #(.DW(DW), .DEPTH(IN_DEPTH)) u_in (
    .clk_i, .rst_ni, .wr_i(pkt_wr_i), .wr_addr_i(pkt_addr_i), .wr_data_i(pkt_data_i),
    .start_i(pkt_start_i), .start_len_i(pkt_len_i), .step_i(step),
    .pending_o(pending), .byte_o(in_byte)
  );

  assign dir       = acr_q[DIR_BIT];
  assign in_step   = step && pending;
  assign out_push  = step && dir;
  assign push_byte = in_step ? in_byte : sr_q;
  assign close     = acr_we_i && dir && !acr_wdata_i[DIR_BIT];

  bxe_out_buf #(.DW(DW), .DEPTH(OUT_DEPTH)) u_out (
    .clk_i, .rst_ni, .push_i(out_push), .byte_i(push_byte), .close_i(close),
    .valid_o(out_valid_o), .len_o(out_len_o), .data_o(out_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      acr_q      <= '0;
      dry_q      <= 1'b1;
      flag_set_o <= 1'b0;
    end else begin
      if (sr_we_i)      sr_q <= sr_wdata_i;
      else if (in_step) sr_q <= in_byte;
      if (acr_we_i) acr_q <= acr_wdata_i;
      // inbound exhaustion seen by the host once it steps past the end
      if (pkt_start_i || sr_we_i)         dry_q <= 1'b0;
      else if (step && !pending && !dir)  dry_q <= 1'b1;
      flag_set_o <= pkt_start_i || in_step || out_push;
    end
  end

  always_comb begin
    portb_o          = b_q;
    portb_o[REQ_BIT] = !pending;
  end

  assign sr_rdata_o = dry_q ? '0 : sr_q;

  // R4
  in_step_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_step |=> flag_set_o);
  // R5
  dry_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !pending && !dir && !sr_we_i && !pkt_start_i) |=> sr_rdata_o == '0);
endmodule

// File: tb/byte_xfer_engine_tb.sv
module byte_xfer_engine_tb;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         portb_we_i = 0, acr_we_i = 0, sr_we_i = 0, pkt_wr_i = 0, pkt_start_i = 0;
  logic [7:0]   portb_wdata_i = 0, acr_wdata_i = 0, sr_wdata_i = 0, pkt_data_i = 0, pkt_len_i = 0;
  logic [6:0]   pkt_addr_i = 0;
  logic [7:0]   portb_o, sr_rdata_o;
  logic         out_valid_o, flag_set_o;
  logic [4:0]   out_len_o;
  logic [127:0] out_data_o;

  int checks = 0, fails = 0;
  logic [7:0] pb_last = 8'hFF;

  always #10 clk = ~clk;

  byte_xfer_engine u_dut (
    .clk_i(clk), .rst_ni, .portb_we_i, .portb_wdata_i, .portb_o,
    .acr_we_i, .acr_wdata_i, .sr_we_i, .sr_wdata_i, .sr_rdata_o,
    .pkt_wr_i, .pkt_addr_i, .pkt_data_i, .pkt_start_i, .pkt_len_i,
    .out_valid_o, .out_len_o, .out_data_o, .flag_set_o
  );

  typedef struct packed {
    logic [1:0] op;      // 0 port, 1 control, 2 shift reg, 3 load
    logic [7:0] d;
    logic       e_flag;
    logic       e_req;
    logic [7:0] e_rd;
    logic       e_ov;
    logic [4:0] e_len;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 8'd3,  1'b1, 1'b0, 8'h00, 1'b0, 5'd0},
    '{2'd0, 8'h18, 1'b1, 1'b0, 8'hA0, 1'b0, 5'd0},
    '{2'd0, 8'h08, 1'b1, 1'b0, 8'hA1, 1'b0, 5'd0},
    '{2'd0, 8'h08, 1'b0, 1'b0, 8'hA1, 1'b0, 5'd0},
    '{2'd0, 8'h38, 1'b0, 1'b0, 8'hA1, 1'b0, 5'd0},
    '{2'd0, 8'h18, 1'b1, 1'b1, 8'hA2, 1'b0, 5'd0},
    '{2'd0, 8'h08, 1'b0, 1'b1, 8'h00, 1'b0, 5'd0},
    '{2'd1, 8'h10, 1'b0, 1'b1, 8'h00, 1'b0, 5'd0},
    '{2'd2, 8'h55, 1'b0, 1'b1, 8'h55, 1'b0, 5'd0},
    '{2'd0, 8'h18, 1'b1, 1'b1, 8'h55, 1'b0, 5'd0},
    '{2'd2, 8'h66, 1'b0, 1'b1, 8'h66, 1'b0, 5'd0},
    '{2'd0, 8'h08, 1'b1, 1'b1, 8'h66, 1'b0, 5'd0},
    '{2'd1, 8'h00, 1'b0, 1'b1, 8'h66, 1'b1, 5'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    case (op)
      2'd0: begin portb_we_i = 1; portb_wdata_i = d; pb_last = d; end
      2'd1: begin acr_we_i = 1; acr_wdata_i = d; end
      2'd2: begin sr_we_i = 1; sr_wdata_i = d; end
      default: begin pkt_start_i = 1; pkt_len_i = d; end
    endcase
    @(posedge clk);
    @(negedge clk);
    portb_we_i = 0; acr_we_i = 0; sr_we_i = 0; pkt_start_i = 0;
  endtask

  task automatic toggle_step();
    do_op(2'd0, (pb_last == 8'h18) ? 8'h08 : 8'h18);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 portb", portb_o, 8'hFF);
    chk("R1 sr", sr_rdata_o, 8'h00);
    chk("R1 valid", out_valid_o, 0);
    chk("R1 flag", flag_set_o, 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      pkt_wr_i = 1; pkt_addr_i = 7'(i); pkt_data_i = 8'(8'hA0 + i);
    end
    @(negedge clk); pkt_wr_i = 0;

    // R2 R3 R4 R5 R6 R7 R8 table walk
    for (int v = 0; v < NV; v++) begin
      do_op(VECS[v].op, VECS[v].d);
      chk($sformatf("R3/R4/R6/R8 flag v%0d", v), flag_set_o, VECS[v].e_flag);
      chk($sformatf("R2 req v%0d", v), portb_o[3], VECS[v].e_req);
      chk($sformatf("R4/R5 sr v%0d", v), sr_rdata_o, VECS[v].e_rd);
      chk($sformatf("R7 valid v%0d", v), out_valid_o, VECS[v].e_ov);
      if (VECS[v].e_ov) chk($sformatf("R7 len v%0d", v), out_len_o, VECS[v].e_len);
    end
    // R9 byte order of the closed packet
    chk("R9 byte0", out_data_o[7:0], 8'h55);
    chk("R9 byte1", out_data_o[15:8], 8'h66);
    chk("R2 echo", portb_o & 8'hF7, 8'h00);

    // R6 overflow: 17 steps, cap at 16, flag every time
    do_op(2'd1, 8'h10);
    for (int i = 0; i < 17; i++) begin
      do_op(2'd2, 8'(i + 1));
      toggle_step();
      chk($sformatf("R6 flag step %0d", i), flag_set_o, 1);
    end
    do_op(2'd1, 8'h00);
    chk("R7 valid full", out_valid_o, 1);
    chk("R6 len full", out_len_o, 5'd16);
    for (int k = 0; k < 16; k++)
      chk($sformatf("R9 byte%0d", k), out_data_o[8*k +: 8], 8'(k + 1));
    @(negedge clk);
    chk("R7 pulse width", out_valid_o, 0);

    // R7 empty close gives no pulse
    do_op(2'd1, 8'h10);
    do_op(2'd1, 8'h00);
    chk("R7 empty close", out_valid_o, 0);

    // R8 reload mid-packet rewinds
    do_op(2'd3, 8'd3);
    toggle_step();
    chk("R8 first", sr_rdata_o, 8'hA0);
    do_op(2'd3, 8'd3);
    chk("R8 reload flag", flag_set_o, 1);
    toggle_step();
    chk("R8 rewind", sr_rdata_o, 8'hA0);

    // R10 full-length inbound packet
    do_op(2'd3, 8'd128);
    for (int i = 0; i < 128; i++) begin
      chk($sformatf("R2 req pend %0d", i), portb_o[3], 0);
      toggle_step();
      chk($sformatf("R10 byte %0d", i), sr_rdata_o, 8'(8'hA0 + i));
    end
    chk("R2 req done", portb_o[3], 1);
    toggle_step();
    chk("R5 past end", sr_rdata_o, 8'h00);
    chk("R3 no flag past end", flag_set_o, 0);
    finish_run();
  end
endmodule